// File: doc/BRIEF.md
# SDRAM Data Mask and Clock-Suspend Stage

This block sits on the memory side of an SDRAM data path, between the burst sequencing logic and the bidirectional data pins. It applies the per-beat byte-mask input and the clock-enable input to read and write bursts. A read beat takes two stages to reach the data pins, and the mask sampled with that beat travels with it, so a masked read beat turns the output driver off two clocks after the mask was seen. A write beat is gated in the same clock it is presented: a high mask suppresses the write strobe for that beat, and the burst still moves on to the next beat.

The clock-enable input is registered once, so the internal clock is enabled or frozen one clock after the input changes, in both directions. A frozen cycle advances nothing. The burst counter, the read pipeline with its mask bits, and the output data register all keep their values, so the transfer stretches out in time and no beat is dropped. Command decoding and the storage array belong to neighbouring blocks. The read and write burst flags from those blocks are expected to be exclusive. If both are high, the read is served.

Top module: `dio_mask_stage`

## Requirements
- R1: During reset and in the first cycle after it, the output enable is low, the read output data is zero, the write strobe is low and the burst counter is zero. The internal clock comes out of reset enabled.
- R2: An active cycle with the read flag high captures the read data input. That data appears on the read output in the cycle two active cycles later, with the output enable high when the mask was low.
- R3: A read beat taken with the mask high holds the output enable low in its output slot two active cycles later. The beats on either side of it are unaffected.
- R4: The write strobe is high in an active cycle with the write flag high and the mask low, in that same cycle (zero mask latency). The write data output always equals the write data input.
- R5: A masked write beat still raises the burst-advance output and increments the burst counter. Only the strobe is suppressed.
- R6: A clock-enable input sampled low at an edge freezes the following cycle. In that cycle burst-advance and the write strobe are low, and the counter, the output enable and the read output data hold their values.
- R7: A clock-enable input sampled high at an edge makes the following cycle active. Burst-advance is then high exactly when either burst flag is high.
- R8: The burst counter increments by one, modulo 2^CNT_W, on each active cycle with burst-advance high. It returns to zero on an active cycle with no burst flag.
- R9: With both burst flags high in an active cycle, the beat is handled as a read: no write strobe is raised, and the read data enters the pipeline.
- R10: The output enable is low in any output slot whose beat was taken with the read flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock-enable input; low suspends the following cycle |
| dqm_i | input | 1 | Data mask for the beat presented this cycle |
| rd_burst_i | input | 1 | A read beat is presented this cycle |
| wr_burst_i | input | 1 | A write beat is presented this cycle |
| rd_data_i | input | DATA_W | Read data from the array for this beat |
| wr_data_i | input | DATA_W | Write data for this beat |
| dq_oe_o | output | 1 | Output driver enable for the data pins |
| dq_out_o | output | DATA_W | Read data driven onto the data pins |
| wr_strobe_o | output | 1 | Write strobe for the current beat |
| wr_data_o | output | DATA_W | Write data toward the array |
| burst_adv_o | output | 1 | Burst position moves on this cycle |
| burst_cnt_o | output | CNT_W | Burst beat counter |

## Verification
A mask bit that slips by one stage in the read pipeline shows up as a misplaced high-impedance slot on the output enable. It appears two active cycles after the faulty beat, and a per-cycle comparison catches it there. A clock-enable register that is bypassed or held wrong shows in the very next cycle, through burst-advance or a moved counter while the model is frozen. A counter fault shows on the counter output in the cycle after the bad step, and it persists until the next idle active cycle clears it.

// File: rtl/dio_pkg.sv
package dio_pkg;

    // Read beat travels this many active cycles to the pins.
    localparam int unsigned RD_PIPE_DEPTH = 2;

    typedef enum logic [1:0] {
        BEAT_IDLE  = 2'd0,
        BEAT_READ  = 2'd1,
        BEAT_WRITE = 2'd2
    } beat_kind_e;

    function automatic beat_kind_e classify_beat(input logic rd, input logic wr);
        if (rd)      return BEAT_READ;
        else if (wr) return BEAT_WRITE;
        else         return BEAT_IDLE;
    endfunction

endpackage

// File: rtl/dio_cke_gate.sv
module dio_cke_gate (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cke_i,
    output logic active_o
);

    typedef struct packed {
        logic active;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.active = cke_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.active <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;

endmodule

// File: rtl/dio_rd_pipe.sv
module dio_rd_pipe #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              beat_i,
    input  logic              mask_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              oe_o,
    output logic [DATA_W-1:0] data_o
);

    localparam int unsigned LAST = DEPTH - 1;

    typedef struct packed {
        logic              valid;
        logic              mask;
        logic [DATA_W-1:0] data;
    } beat_t;

    beat_t [DEPTH-1:0] stage_d, stage_q;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_head
                always_comb begin
                    stage_d[g] = stage_q[g];
                    if (en_i) begin
                        stage_d[g].valid = beat_i;
                        stage_d[g].mask  = mask_i;
                        stage_d[g].data  = data_i;
                    end
                end
            end else begin : g_body
                always_comb begin
                    stage_d[g] = stage_q[g];
                    if (en_i) begin
                        stage_d[g] = stage_q[g-1];
                    end
                end
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    stage_q[g] <= '0;
                end else begin
                    stage_q[g] <= stage_d[g];
                end
            end
        end
    endgenerate

    assign oe_o   = stage_q[LAST].valid & ~stage_q[LAST].mask;
    assign data_o = stage_q[LAST].data;

endmodule

// File: rtl/dio_burst_ctr.sv
module dio_burst_ctr #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             adv_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            if (adv_i) st_d.cnt = st_q.cnt + ONE;
            else       st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/dio_mask_stage.sv
module dio_mask_stage
    import dio_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cke_i,
    input  logic              dqm_i,
    input  logic              rd_burst_i,
    input  logic              wr_burst_i,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              dq_oe_o,
    output logic [DATA_W-1:0] dq_out_o,
    output logic              wr_strobe_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              burst_adv_o,
    output logic [CNT_W-1:0]  burst_cnt_o
);

    logic       active;
    beat_kind_e kind;
    logic       rd_beat;
    logic       wr_beat;

    dio_cke_gate u_cke (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .cke_i    (cke_i),
        .active_o (active)
    );

    always_comb begin
        kind    = classify_beat(rd_burst_i, wr_burst_i);
        rd_beat = (kind == BEAT_READ);
        wr_beat = (kind == BEAT_WRITE);
    end

    dio_rd_pipe #(
        .DATA_W (DATA_W),
        .DEPTH  (RD_PIPE_DEPTH)
    ) u_rd_pipe (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (active),
        .beat_i (rd_beat),
        .mask_i (dqm_i),
        .data_i (rd_data_i),
        .oe_o   (dq_oe_o),
        .data_o (dq_out_o)
    );

    dio_burst_ctr #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (active),
        .adv_i  (burst_adv_o),
        .cnt_o  (burst_cnt_o)
    );

    assign burst_adv_o = active & (kind != BEAT_IDLE);
    assign wr_strobe_o = active & wr_beat & ~dqm_i;
    assign wr_data_o   = wr_data_i;

endmodule

// File: rtl/dio_mask_stage_chk.sv
module dio_mask_stage_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              cke_i,
    input logic              dqm_i,
    input logic              rd_burst_i,
    input logic              wr_burst_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              dq_oe_o,
    input logic [DATA_W-1:0] dq_out_o,
    input logic              wr_strobe_o,
    input logic [DATA_W-1:0] wr_data_o,
    input logic              burst_adv_o,
    input logic [CNT_W-1:0]  burst_cnt_o
);

    logic en_seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_seen_q <= 1'b1;
        else         en_seen_q <= cke_i;
    end

    AST_WR_MASK_ZERO_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dqm_i |-> !wr_strobe_o); // R4

    AST_WR_DATA_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_data_o == wr_data_i); // R4

    AST_STROBE_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_strobe_o |-> (wr_burst_i && burst_adv_o)); // R5

    AST_READ_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_burst_i |-> !wr_strobe_o); // R9

    AST_FREEZE_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cke_i |=> (!burst_adv_o && !wr_strobe_o)); // R6

    AST_FREEZE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cke_i |=> ##1 ($stable(burst_cnt_o) && $stable(dq_oe_o) && $stable(dq_out_o))); // R6

    AST_RESUME_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cke_i |=> (burst_adv_o == (rd_burst_i || wr_burst_i))); // R7

    AST_RD_MASK_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_seen_q && cke_i && rd_burst_i && dqm_i) |=> ##1 !dq_oe_o); // R3

    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        burst_adv_o |=> (burst_cnt_o == CNT_W'($past(burst_cnt_o) + 1'b1))); // R8

endmodule

bind dio_mask_stage dio_mask_stage_chk #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cke_i       (cke_i),
    .dqm_i       (dqm_i),
    .rd_burst_i  (rd_burst_i),
    .wr_burst_i  (wr_burst_i),
    .wr_data_i   (wr_data_i),
    .dq_oe_o     (dq_oe_o),
    .dq_out_o    (dq_out_o),
    .wr_strobe_o (wr_strobe_o),
    .wr_data_o   (wr_data_o),
    .burst_adv_o (burst_adv_o),
    .burst_cnt_o (burst_cnt_o)
);

// File: tb/dio_mask_stage_tb_top.sv
module dio_mask_stage_tb_top;

    localparam int DW = 8;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke = 1'b1, dqm = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [DW-1:0] rdat = '0, wdat = '0;
    logic          oe, strobe, adv;
    logic [DW-1:0] dq, wout;
    logic [CW-1:0] cnt;

    always #10 clk = ~clk;

    dio_mask_stage #(.DATA_W(DW), .CNT_W(CW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .dqm_i(dqm),
        .rd_burst_i(rd), .wr_burst_i(wr), .rd_data_i(rdat), .wr_data_i(wdat),
        .dq_oe_o(oe), .dq_out_o(dq), .wr_strobe_o(strobe), .wr_data_o(wout),
        .burst_adv_o(adv), .burst_cnt_o(cnt)
    );

    typedef struct { bit v; bit m; logic [DW-1:0] d; } beat_t;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string ctx    = "R2";

    // reference model state
    bit    m_act;
    int    m_cnt;
    beat_t m_q[$];
    beat_t m_out;

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        beat_t z;
        z.v = 0; z.m = 0; z.d = '0;
        m_act = 1; m_cnt = 0;
        m_q.delete();
        m_q.push_back(z);
        m_out = z;
    endtask

    task automatic compare();
        bit exp_adv, exp_stb;
        exp_adv = m_act && (rd || wr);
        exp_stb = m_act && wr && !rd && !dqm;
        check(ctx, "burst_adv", int'(adv), int'(exp_adv));
        check(ctx, "wr_strobe", int'(strobe), int'(exp_stb));
        check(ctx, "wr_data", int'(wout), int'(wdat));
        check(ctx, "burst_cnt", int'(cnt), m_cnt);
        check(ctx, "dq_oe", int'(oe), int'(m_out.v && !m_out.m));
        check(ctx, "dq_out", int'(dq), int'(m_out.d));
    endtask

    task automatic step(input bit c, input bit m, input bit r, input bit w,
                        input logic [DW-1:0] rd_v, input logic [DW-1:0] wr_v);
        beat_t nb;
        bit    n_act;
        int    n_cnt;
        beat_t n_out;
        @(negedge clk);
        cke = c; dqm = m; rd = r; wr = w; rdat = rd_v; wdat = wr_v;
        #1;
        compare();
        n_act = c;
        n_cnt = m_cnt;
        n_out = m_out;
        if (m_act) begin
            n_cnt = (r || w) ? ((m_cnt + 1) % (1 << CW)) : 0;
            nb.v = r; nb.m = m; nb.d = rd_v;
            m_q.push_back(nb);
            n_out = m_q.pop_front();
        end
        @(posedge clk);
        m_act = n_act; m_cnt = n_cnt; m_out = n_out;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs during reset
        check("R1", "oe in reset", int'(oe), 0);
        check("R1", "cnt in reset", int'(cnt), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", "strobe after reset", int'(strobe), 0);
        check("R1", "dq after reset", int'(dq), 0);
        check("R1", "adv after reset (enabled)", int'(adv), 0);

        // R2 / R3 / R10: read burst, mask on third beat, idle slots after
        ctx = "R3";
        for (int i = 0; i < 5; i++) step(1, i == 2, 1, 0, 8'h30 + 8'(i), 8'h00);
        ctx = "R10";
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 8'hEE, 8'h00);

        // R4 / R5: write burst, mask on beats 1 and 3
        ctx = "R5";
        for (int i = 0; i < 5; i++) step(1, (i % 2) == 1, 0, 1, 8'h00, 8'hA0 + 8'(i));
        step(1, 0, 0, 0, 8'h00, 8'h00);

        // R6 / R7: suspend in the middle of a read burst, then in a write burst
        ctx = "R6";
        step(1, 0, 1, 0, 8'h51, 8'h00);
        step(0, 0, 1, 0, 8'h52, 8'h00);
        step(0, 1, 1, 0, 8'h53, 8'h00);
        step(0, 0, 1, 0, 8'h54, 8'h00);
        ctx = "R7";
        step(1, 0, 1, 0, 8'h55, 8'h00);
        step(1, 1, 1, 0, 8'h56, 8'h00);
        step(1, 0, 1, 0, 8'h57, 8'h00);
        ctx = "R6";
        step(0, 0, 0, 1, 8'h00, 8'h61);
        step(1, 0, 0, 1, 8'h00, 8'h62);
        ctx = "R7";
        step(1, 0, 0, 1, 8'h00, 8'h63);
        step(1, 0, 0, 0, 8'h00, 8'h00);
        step(1, 0, 0, 0, 8'h00, 8'h00);

        // R9: both flags high
        ctx = "R9";
        step(1, 0, 1, 1, 8'h77, 8'h88);
        step(1, 0, 1, 1, 8'h78, 8'h89);
        step(1, 0, 0, 0, 8'h00, 8'h00);
        step(1, 0, 0, 0, 8'h00, 8'h00);

        // R8: long burst wraps the counter, then idle clears it
        ctx = "R8";
        for (int i = 0; i < 20; i++) step(1, 0, 0, 1, 8'h00, 8'(i));
        step(1, 0, 0, 0, 8'h00, 8'h00);
        step(1, 0, 0, 0, 8'h00, 8'h00);

        // mixed pseudo-random traffic
        ctx = "R2";
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            r = $urandom;
            step((r % 5) != 0, r[4] & r[5], r[8] & ~r[9], r[10] & ~r[11],
                 8'(r >> 12), 8'(r >> 20));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule